// File: doc/BRIEF.md
# Sub-word load/store data steering

This block sits between a 32-bit core register file and a 32-bit memory data bus and moves byte, halfword and word quantities across it. On the store side it takes a register value, a two-bit transfer size and the low bits of the byte address. It drives the write bus with the sub-word copied into every lane that could hold it, so the memory side only has to decode the address into per-lane write enables. On the load side it takes the 32-bit word read from the bus and returns the addressed byte or halfword, right-aligned and zero-extended.

Lane numbering follows a static endian input. Extraction reads only the lanes that belong to the addressed quantity. A memory may therefore return the whole word or drive only the addressed lanes, and the result is the same. An optional output register, chosen by a parameter, puts one cycle of latency on all three outputs.

Top module: `subword_steer`

## Requirements
- R1: The size code is decoded as 00 byte, 01 halfword, 10 word and 11 reserved.
- R2: For a word transfer the write bus equals the store register and the load result equals the bus word; both address bits are ignored.
- R3: For a byte store, bits 7:0 of the store register appear on all four write-bus lanes, whatever the address and endian mode.
- R4: For a halfword store, bits 15:0 of the store register appear on both bus[15:0] and bus[31:16], whatever the address and endian mode.
- R5: For a byte load in little endian mode (big_endian_i = 0), memory byte k (k = addr_lo_i) is read from bus bits 8k+7:8k.
- R6: For a byte load in big endian mode (big_endian_i = 1), memory byte k is read from bus bits 31-8k:24-8k.
- R7: For a halfword load, addr_lo_i[1] = 0 selects bus[15:0] in little endian and bus[31:16] in big endian, and addr_lo_i[1] = 1 selects the other half; addr_lo_i[0] has no effect.
- R8: Byte load results have bits 31:8 at zero, and halfword load results have bits 31:16 at zero.
- R9: With size code 11, size_err_o is 1 and both the load result and the write bus are zero; for every other code size_err_o is 0.
- R10: Bus lanes outside the addressed byte or halfword do not affect the load result.
- R11: With OUT_REG = 1 every output reflects the inputs present at the previous rising clock edge; with OUT_REG = 0 the outputs follow the inputs combinationally.
- R12: With OUT_REG = 1, a synchronous active-high reset drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| big_endian_i | input | 1 | Static lane order: 0 little endian, 1 big endian |
| size_i | input | 2 | Transfer size code |
| addr_lo_i | input | 2 | Low two bits of the byte address |
| store_data_i | input | 32 | Register value to be stored |
| bus_rdata_i | input | 32 | Word read from the memory data bus |
| bus_wdata_o | output | 32 | Word driven onto the memory data bus |
| load_data_o | output | 32 | Extracted, zero-extended load result |
| size_err_o | output | 1 | Reserved size code seen |

## Verification
The bench sweeps every combination of size code, address offset and endian mode, using distinct byte values in every lane. Because every lane differs, choosing the wrong lane or swapping halves shows up as a different value rather than an accidental match. Each sub-word load is repeated twice: once with the whole word on the bus and once with only the addressed lanes driven and the others zero or filled with other data. This separates extraction that reads only the addressed lanes from extraction that leaks neighbouring lanes. Reset is applied both at the start and in the middle of traffic, and one check looks at the outputs just after new inputs are driven, which shows whether the output register adds its cycle of delay.

// File: rtl/steer_pkg.sv
package steer_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;

    typedef struct packed {
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } steer_out_t;

    // Physical lane holding memory byte k for the given ordering.
    function automatic logic [LANE_W-1:0] lane_of(input logic [LANE_W-1:0] k,
                                                  input logic big);
        return big ? ~k : k;
    endfunction

    function automatic logic [7:0] pick_lane(input logic [DATA_W-1:0] w,
                                             input logic [LANE_W-1:0] lane);
        logic [7:0] r;
        case (lane)
            2'd0:    r = w[7:0];
            2'd1:    r = w[15:8];
            2'd2:    r = w[23:16];
            default: r = w[31:24];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/store_lane_fill.sv
module store_lane_fill
    import steer_pkg::*;
(
    input  xfer_size_e        size,
    input  logic [DATA_W-1:0] reg_data,
    output logic [DATA_W-1:0] wdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_BYTE: wdata[8*g +: 8] = reg_data[7:0];
                SZ_HALF: wdata[8*g +: 8] = reg_data[8*(g % 2) +: 8];
                SZ_WORD: wdata[8*g +: 8] = reg_data[8*g +: 8];
                default: wdata[8*g +: 8] = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/load_lane_pick.sv
module load_lane_pick
    import steer_pkg::*;
(
    input  xfer_size_e        size,
    input  logic [1:0]        addr_lo,
    input  logic              big,
    input  logic [DATA_W-1:0] bus,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);

    logic [LANE_W-1:0] byte_lane;
    logic              upper_half;
    logic [15:0]       half_val;

    assign byte_lane  = lane_of(addr_lo, big);
    assign upper_half = addr_lo[1] ^ big;
    assign half_val   = upper_half ? bus[31:16] : bus[15:0];

    always_comb begin
        err   = 1'b0;
        rdata = '0;
        unique case (size)
            SZ_BYTE: rdata[7:0]  = pick_lane(bus, byte_lane);
            SZ_HALF: rdata[15:0] = half_val;
            SZ_WORD: rdata       = bus;
            default: err         = 1'b1;
        endcase
    end

endmodule

// File: rtl/steer_out_stage.sv
module steer_out_stage
    import steer_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  steer_out_t d,
    output steer_out_t q
);

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= d;
        end
    end else begin : g_comb
        logic unused_ok;
        assign unused_ok = clk ^ rst;
        assign q = d;
    end

endmodule

// File: rtl/subword_steer.sv
module subword_steer
    import steer_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              big_endian_i,
    input  logic [1:0]        size_i,
    input  logic [1:0]        addr_lo_i,
    input  logic [DATA_W-1:0] store_data_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic [DATA_W-1:0] load_data_o,
    output logic              size_err_o
);

    xfer_size_e size_e;
    steer_out_t comb_out;
    steer_out_t reg_out;

    assign size_e = xfer_size_e'(size_i);

    store_lane_fill u_fill (
        .size     (size_e),
        .reg_data (store_data_i),
        .wdata    (comb_out.wdata)
    );

    load_lane_pick u_pick (
        .size    (size_e),
        .addr_lo (addr_lo_i),
        .big     (big_endian_i),
        .bus     (bus_rdata_i),
        .rdata   (comb_out.rdata),
        .err     (comb_out.err)
    );

    steer_out_stage #(.OUT_REG(OUT_REG)) u_stage (
        .clk (clk),
        .rst (rst),
        .d   (comb_out),
        .q   (reg_out)
    );

    assign bus_wdata_o = reg_out.wdata;
    assign load_data_o = reg_out.rdata;
    assign size_err_o  = reg_out.err;

endmodule

// File: rtl/subword_steer_chk.sv
module subword_steer_chk
    import steer_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        size_i,
    input logic [DATA_W-1:0] store_data_i,
    input logic [DATA_W-1:0] bus_rdata_i,
    input logic [DATA_W-1:0] bus_wdata_o,
    input logic [DATA_W-1:0] load_data_o,
    input logic              size_err_o
);

    logic [1:0]        sz_d;
    logic [DATA_W-1:0] st_d;
    logic [DATA_W-1:0] rd_d;

    if (OUT_REG) begin : g_dly
        always_ff @(posedge clk) begin
            if (rst) begin
                sz_d <= '0;
                st_d <= '0;
                rd_d <= '0;
            end else begin
                sz_d <= size_i;
                st_d <= store_data_i;
                rd_d <= bus_rdata_i;
            end
        end
    end else begin : g_now
        assign sz_d = size_i;
        assign st_d = store_data_i;
        assign rd_d = bus_rdata_i;
    end

    // R3
    a_r3_byte_fill: assert property (@(posedge clk) disable iff (rst)
        sz_d == 2'b00 |-> (bus_wdata_o[7:0] == st_d[7:0]) &&
                          (bus_wdata_o[15:8] == st_d[7:0]) &&
                          (bus_wdata_o[23:16] == st_d[7:0]) &&
                          (bus_wdata_o[31:24] == st_d[7:0]));

    // R4
    a_r4_half_fill: assert property (@(posedge clk) disable iff (rst)
        sz_d == 2'b01 |-> (bus_wdata_o[15:0] == st_d[15:0]) &&
                          (bus_wdata_o[31:16] == st_d[15:0]));

    // R2
    a_r2_word_pass: assert property (@(posedge clk) disable iff (rst)
        sz_d == 2'b10 |-> (bus_wdata_o == st_d) && (load_data_o == rd_d));

    // R8
    a_r8_byte_zext: assert property (@(posedge clk) disable iff (rst)
        sz_d == 2'b00 |-> load_data_o[31:8] == '0);

    a_r8_half_zext: assert property (@(posedge clk) disable iff (rst)
        sz_d == 2'b01 |-> load_data_o[31:16] == '0);

    // R9
    a_r9_err_flag: assert property (@(posedge clk) disable iff (rst)
        size_err_o == (sz_d == 2'b11));

    a_r9_err_quiet: assert property (@(posedge clk) disable iff (rst)
        size_err_o |-> (load_data_o == '0) && (bus_wdata_o == '0));

endmodule

bind subword_steer subword_steer_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .size_i       (size_i),
    .store_data_i (store_data_i),
    .bus_rdata_i  (bus_rdata_i),
    .bus_wdata_o  (bus_wdata_o),
    .load_data_o  (load_data_o),
    .size_err_o   (size_err_o)
);

// File: tb/test_subword_steer.sv
module test_subword_steer;

    localparam bit OUT_REG = 1'b1;

    logic        clk = 1'b0;
    logic        rst;
    logic        big_endian_i;
    logic [1:0]  size_i;
    logic [1:0]  addr_lo_i;
    logic [31:0] store_data_i;
    logic [31:0] bus_rdata_i;
    logic [31:0] bus_wdata_o;
    logic [31:0] load_data_o;
    logic        size_err_o;

    always #5 clk = ~clk;

    subword_steer #(.OUT_REG(OUT_REG)) i_subword_steer (
        .clk          (clk),
        .rst          (rst),
        .big_endian_i (big_endian_i),
        .size_i       (size_i),
        .addr_lo_i    (addr_lo_i),
        .store_data_i (store_data_i),
        .bus_rdata_i  (bus_rdata_i),
        .bus_wdata_o  (bus_wdata_o),
        .load_data_o  (load_data_o),
        .size_err_o   (size_err_o)
    );

    typedef struct {
        logic [31:0] w;
        logic [31:0] r;
        logic        e;
        string       tag_st;
        string       tag_ld;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // Memory byte k of the bus word, by lane ordering.
    function automatic logic [7:0] mem_byte(logic [31:0] bus, int k, logic be);
        int lane = be ? 3 - k : k;
        return bus[8*lane +: 8];
    endfunction

    function automatic logic [31:0] model_load(logic [1:0] sz, logic [1:0] a,
                                               logic be, logic [31:0] bus);
        int h;
        case (sz)
            2'b00: return {24'h0, mem_byte(bus, int'(a), be)};
            2'b01: begin
                h = a[1] ? 2 : 0;
                if (be) return {16'h0, mem_byte(bus, h, be), mem_byte(bus, h + 1, be)};
                else    return {16'h0, mem_byte(bus, h + 1, be), mem_byte(bus, h, be)};
            end
            2'b10:   return bus;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] model_store(logic [1:0] sz, logic [31:0] s);
        case (sz)
            2'b00:   return {4{s[7:0]}};
            2'b01:   return {2{s[15:0]}};
            2'b10:   return s;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic apply(logic be, logic [1:0] sz, logic [1:0] a,
                         logic [31:0] st, logic [31:0] rd);
        exp_t e;
        @(negedge clk);
        big_endian_i = be; size_i = sz; addr_lo_i = a;
        store_data_i = st; bus_rdata_i = rd;
        e.w = model_store(sz, st);
        e.r = model_load(sz, a, be, rd);
        e.e = (sz == 2'b11);
        case (sz)
            2'b00:   begin e.tag_st = "R3"; e.tag_ld = be ? "R6" : "R5"; end
            2'b01:   begin e.tag_st = "R4"; e.tag_ld = "R7"; end
            2'b10:   begin e.tag_st = "R2"; e.tag_ld = "R2"; end
            default: begin e.tag_st = "R9"; e.tag_ld = "R9"; end
        endcase
        exp_q.push_back(e);
        if (OUT_REG) @(posedge clk);
        #1;
        e = exp_q.pop_front();
        chk(e.tag_st, "store bus", bus_wdata_o, e.w);
        chk(e.tag_ld, "load result", load_data_o, e.r);
        chk("R1 R9", "size error", {31'h0, size_err_o}, {31'h0, e.e});
        if (sz == 2'b00) chk("R8", "byte zero-ext", {8'h0, load_data_o[31:8]}, 32'h0);
        if (sz == 2'b01) chk("R8", "half zero-ext", {16'h0, load_data_o[31:16]}, 32'h0);
    endtask

    // Sub-word load with only the addressed lanes driven, versus full word.
    task automatic sparse_load(logic be, logic [1:0] sz, logic [1:0] a, logic [31:0] full);
        logic [31:0] msk = 32'h0;
        logic [31:0] want;
        for (int k = 0; k < 4; k++) begin
            int lane = be ? 3 - k : k;
            if ((sz == 2'b00 && k == int'(a)) ||
                (sz == 2'b01 && (k >> 1) == int'(a[1])))
                msk[8*lane +: 8] = 8'hFF;
        end
        want = model_load(sz, a, be, full);
        @(negedge clk);
        big_endian_i = be; size_i = sz; addr_lo_i = a;
        store_data_i = 32'h0; bus_rdata_i = full & msk;
        if (OUT_REG) @(posedge clk);
        #1;
        chk("R10", "lanes driven only", load_data_o, want);
        @(negedge clk);
        bus_rdata_i = (full & msk) | (~msk & 32'h5AA5_C33C);
        if (OUT_REG) @(posedge clk);
        #1;
        chk("R10", "foreign lanes filled", load_data_o, want);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] st;
        logic [31:0] rd;
        rst = 1'b1;
        big_endian_i = 1'b0; size_i = 2'b10; addr_lo_i = 2'b11;
        store_data_i = 32'hDEAD_BEEF; bus_rdata_i = 32'hCAFE_F00D;
        repeat (3) @(posedge clk);
        #1;
        // R12: outputs held at zero during reset
        chk("R12", "reset store bus", bus_wdata_o, 32'h0);
        chk("R12", "reset load", load_data_o, 32'h0);
        chk("R12", "reset err", {31'h0, size_err_o}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // Full sweep with distinct lane values
        for (int pass = 0; pass < 3; pass++) begin
            for (int be = 0; be < 2; be++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    for (int a = 0; a < 4; a++) begin
                        case (pass)
                            0: begin st = 32'h8877_6655; rd = 32'h4433_2211; end
                            1: begin st = 32'h0F1E_2D3C; rd = 32'hF0E1_D2C3; end
                            default: begin st = $urandom; rd = $urandom; end
                        endcase
                        apply(logic'(be), 2'(sz), 2'(a), st, rd);
                    end
                end
            end
        end

        // R10: sparse lane presentation
        for (int be = 0; be < 2; be++)
            for (int sz = 0; sz < 2; sz++)
                for (int a = 0; a < 4; a++)
                    sparse_load(logic'(be), 2'(sz), 2'(a), 32'hA1B2_C3D4);

        // R11: output register adds one cycle of delay
        apply(1'b0, 2'b10, 2'b00, 32'h1111_1111, 32'h2222_2222);
        @(negedge clk);
        size_i = 2'b10; store_data_i = 32'h3333_3333; bus_rdata_i = 32'h4444_4444;
        #1;
        if (OUT_REG) chk("R11", "held before edge", load_data_o, 32'h2222_2222);
        else         chk("R11", "follows input", load_data_o, 32'h4444_4444);
        @(posedge clk);
        #1;
        chk("R11", "after edge", load_data_o, 32'h4444_4444);

        // R12: reset in the middle of traffic
        @(negedge clk);
        rst = 1'b1; size_i = 2'b11;
        @(posedge clk);
        #1;
        chk("R12", "mid reset store bus", bus_wdata_o, 32'h0);
        chk("R12", "mid reset load", load_data_o, 32'h0);
        chk("R12", "mid reset err", {31'h0, size_err_o}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        apply(1'b1, 2'b00, 2'b10, 32'h0000_00C7, 32'h1020_3040);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule